// File: doc/BRIEF.md
# Next-PC and Link Computation Unit

This block works out where a simple 32-bit load/store processor fetches next. Each cycle it takes the byte address of the current instruction, the 32-bit instruction word and the value of the source register named by instruction bits 25:21. From these it forms the next program counter. It also drives a write enable and a data value that let the register file store a return address in register 31. The block is purely combinational and sits between decode and fetch.

Six opcodes change control flow. Two conditional branches test the source register against zero and jump by a sign-extended 16-bit offset. Two jumps relative to the program counter carry a sign-extended 26-bit offset, and one of them also saves a return address. Two register-indirect jumps take their target from the source register, and one of them also saves a return address. Every other opcode, and every branch that is not taken, continues with the next sequential instruction.

Top module: `pc_flow_unit`

## Requirements
- R1: The opcode is instruction bits 31:26. Any opcode other than 0x02, 0x03, 0x04, 0x05, 0x12 or 0x13 gives next_pc = pc + 4, taken = 0 and link_wr = 0.
- R2: Opcode 0x04 (branch if zero) with src_val == 0 gives next_pc = pc + 4 + sign-extended instr[15:0] and taken = 1.
- R3: Opcode 0x05 (branch if nonzero) with src_val != 0 gives next_pc = pc + 4 + sign-extended instr[15:0] and taken = 1. Any single set bit in src_val counts as nonzero.
- R4: A branch that is not taken (0x04 with a nonzero source, or 0x05 with a zero source) gives next_pc = pc + 4 and taken = 0.
- R5: Opcode 0x02 (relative jump) gives next_pc = pc + 4 + sign-extended instr[25:0] and taken = 1. Negative offsets are allowed.
- R6: Opcode 0x03 (relative jump with link) gives the same target as R5 and drives link_wr = 1 and link_val = pc + 4.
- R7: Opcode 0x12 (register jump) gives next_pc = src_val and taken = 1.
- R8: Opcode 0x13 (register jump with link) gives next_pc = src_val, taken = 1, link_wr = 1 and link_val = pc + 4.
- R9: link_wr is 1 only for opcodes 0x03 and 0x13. link_val always equals pc + 4.
- R10: taken is 1 for every jump and every taken branch, even when the target happens to equal pc + 4.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc | input | 32 | Byte address of the current instruction |
| instr | input | 32 | Current instruction word |
| src_val | input | 32 | Value of the register selected by instr[25:21] |
| next_pc | output | 32 | Address of the next instruction to fetch |
| taken | output | 1 | A control transfer away from sequential flow took place |
| link_wr | output | 1 | Write the return address to register 31 |
| link_val | output | 32 | Return address (pc + 4) |

## Verification
The bench targets the sign bit of each offset field. A design that zero-extended an offset would send a backward branch or jump far forward. It drives branch sources where only the top bit is set, which catches a zero test that looks at too few bits. It places pc at the top of the address space, so that a carry into a wider sum would show up as a wrong next address. It also jumps through a register whose value equals pc + 4, which exposes a taken flag derived from a target comparison instead of from the decoded control flow.

// File: rtl/pcu_pkg.sv
// Shared types for the next-PC unit.
// Assumes opcodes sit in the top six bits of a 32-bit instruction word.
package pcu_pkg;
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JUMP_REL   = 6'h02;
    localparam logic [OPC_W-1:0] OPC_JUMP_REL_L = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BR_ZERO    = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BR_NZERO   = 6'h05;
    localparam logic [OPC_W-1:0] OPC_JUMP_REG   = 6'h12;
    localparam logic [OPC_W-1:0] OPC_JUMP_REG_L = 6'h13;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BZ,
        FLOW_BNZ,
        FLOW_REL,
        FLOW_REG
    } flow_e;

    typedef struct packed {
        flow_e kind;
        logic  link;
    } flow_t;
endpackage

// File: rtl/pcu_decode.sv
// Decodes the opcode into a control-flow kind and link flag, and
// sign-extends both offset fields to the address width.
// Assumes XLEN is wider than both offset fields.
module pcu_decode
    import pcu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int INSN_W = 32,
    parameter int BOFF_W = 16
) (
    input  logic [INSN_W-1:0] instr,
    output flow_t             flow,
    output logic [XLEN-1:0]   br_off,
    output logic [XLEN-1:0]   jmp_off
);
    localparam int JOFF_W = INSN_W - OPC_W;

    logic [OPC_W-1:0] opc;
    assign opc = instr[INSN_W-1 -: OPC_W];

    // Sign-extend the short branch field and the long jump field.
    assign br_off  = {{(XLEN-BOFF_W){instr[BOFF_W-1]}}, instr[BOFF_W-1:0]};
    assign jmp_off = {{(XLEN-JOFF_W){instr[JOFF_W-1]}}, instr[JOFF_W-1:0]};

    // Map each opcode to its flow kind; everything unlisted is sequential.
    always_comb begin
        flow.kind = FLOW_SEQ;
        flow.link = 1'b0;
        case (opc)
            OPC_BR_ZERO:    flow.kind = FLOW_BZ;
            OPC_BR_NZERO:   flow.kind = FLOW_BNZ;
            OPC_JUMP_REL:   flow.kind = FLOW_REL;
            OPC_JUMP_REL_L: begin flow.kind = FLOW_REL; flow.link = 1'b1; end
            OPC_JUMP_REG:   flow.kind = FLOW_REG;
            OPC_JUMP_REG_L: begin flow.kind = FLOW_REG; flow.link = 1'b1; end
            default:        ;
        endcase
    end

    // Guard: a link request only accompanies an unconditional jump.
    always_comb begin
        if (!$isunknown(instr)) begin
            // R9
            link_only_on_jump_chk: assert (!flow.link || flow.kind == FLOW_REL || flow.kind == FLOW_REG);
        end
    end
endmodule

// File: rtl/pcu_cond.sv
// Resolves whether control flow leaves the sequential path.
// Assumes a full-width zero test on the source register.
module pcu_cond
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_e           kind,
    input  logic [XLEN-1:0] src_val,
    output logic            take
);
    logic src_zero;
    assign src_zero = (src_val == '0);

    // Jumps always transfer; branches depend on the zero test.
    always_comb begin
        case (kind)
            FLOW_REL, FLOW_REG: take = 1'b1;
            FLOW_BZ:            take = src_zero;
            FLOW_BNZ:           take = !src_zero;
            default:            take = 1'b0;
        endcase
    end

    // Guard: sequential instructions never transfer.
    always_comb begin
        if (!$isunknown(src_val)) begin
            // R1
            seq_never_taken_chk: assert (kind != FLOW_SEQ || !take);
        end
    end
endmodule

// File: rtl/pcu_target.sv
// Selects the next fetch address from the sequential address, the
// relative targets and the register target.
// Assumes all sums wrap at XLEN bits.
module pcu_target
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_e           kind,
    input  logic            take,
    input  logic [XLEN-1:0] pc_seq,
    input  logic [XLEN-1:0] br_off,
    input  logic [XLEN-1:0] jmp_off,
    input  logic [XLEN-1:0] src_val,
    output logic [XLEN-1:0] next_pc
);
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;

    // Relative targets are measured from the sequential address.
    assign br_tgt  = pc_seq + br_off;
    assign jmp_tgt = pc_seq + jmp_off;

    // Pick the target for a taken transfer, else fall through.
    always_comb begin
        next_pc = pc_seq;
        if (take) begin
            case (kind)
                FLOW_BZ, FLOW_BNZ: next_pc = br_tgt;
                FLOW_REL:          next_pc = jmp_tgt;
                FLOW_REG:          next_pc = src_val;
                default:           next_pc = pc_seq;
            endcase
        end
    end

    // Guard: target selection agrees with the resolved condition.
    always_comb begin
        if (!$isunknown({pc_seq, src_val, br_off, jmp_off, take})) begin
            // R4
            fallthrough_when_idle_chk: assert (take || next_pc == pc_seq);
            // R7
            reg_target_exact_chk: assert (!(take && kind == FLOW_REG) || next_pc == src_val);
        end
    end
endmodule

// File: rtl/pc_flow_unit.sv
// Next-PC and link unit: computes the next fetch address, the
// transfer flag and the return-address write for register 31.
// Purely combinational; assumes a fixed 4-byte instruction size.
module pc_flow_unit
    import pcu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [INSN_W-1:0] instr,
    input  logic [XLEN-1:0]   src_val,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic              link_wr,
    output logic [XLEN-1:0]   link_val
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    flow_t           flow;
    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] jmp_off;
    logic [XLEN-1:0] pc_seq;
    logic            take;

    // Sequential address doubles as the return address.
    assign pc_seq = pc + STEP;

    pcu_decode #(.XLEN(XLEN), .INSN_W(INSN_W)) u_decode (
        .instr   (instr),
        .flow    (flow),
        .br_off  (br_off),
        .jmp_off (jmp_off)
    );

    pcu_cond #(.XLEN(XLEN)) u_cond (
        .kind    (flow.kind),
        .src_val (src_val),
        .take    (take)
    );

    pcu_target #(.XLEN(XLEN)) u_target (
        .kind    (flow.kind),
        .take    (take),
        .pc_seq  (pc_seq),
        .br_off  (br_off),
        .jmp_off (jmp_off),
        .src_val (src_val),
        .next_pc (next_pc)
    );

    assign taken    = take;
    assign link_wr  = flow.link;
    assign link_val = pc_seq;

    // Guard: a link write always comes with a transfer.
    always_comb begin
        if (!$isunknown({pc, instr, src_val})) begin
            // R9
            link_implies_taken_chk: assert (!link_wr || taken);
        end
    end
endmodule

// File: tb/pc_flow_unit_bench.sv
// Bench for pc_flow_unit: a behavioural reference computes the expected
// outputs for each applied vector and compares them once per clock.
module pc_flow_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc, instr, src_val;
    logic [31:0] next_pc, link_val;
    logic        taken, link_wr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pc_flow_unit u_pc_flow_unit (
        .pc       (pc),
        .instr    (instr),
        .src_val  (src_val),
        .next_pc  (next_pc),
        .taken    (taken),
        .link_wr  (link_wr),
        .link_val (link_val)
    );

    // Behavioural reference: integers and explicit sign extension.
    task automatic reference(input logic [31:0] p, input logic [31:0] w, input logic [31:0] s,
                             output logic [31:0] e_next, output logic e_tk,
                             output logic e_lw, output logic [31:0] e_lv);
        int op;
        longint seqa, boff, joff;
        op   = int'(w >> 26);
        seqa = longint'(p) + 4;
        boff = (w[15] ? longint'(w[15:0]) - 65536 : longint'(w[15:0]));
        joff = (w[25] ? longint'(w[25:0]) - 67108864 : longint'(w[25:0]));
        e_tk = 1'b0;
        e_lw = 1'b0;
        e_lv = seqa[31:0];
        e_next = seqa[31:0];
        if (op == 4 && s == 0)      begin e_tk = 1'b1; e_next = 32'(seqa + boff); end
        else if (op == 5 && s != 0) begin e_tk = 1'b1; e_next = 32'(seqa + boff); end
        else if (op == 2 || op == 3) begin e_tk = 1'b1; e_next = 32'(seqa + joff); e_lw = (op == 3); end
        else if (op == 18 || op == 19) begin e_tk = 1'b1; e_next = s; e_lw = (op == 19); end
    endtask

    function automatic string tag_for(input logic [31:0] w, input logic [31:0] s);
        int op;
        op = int'(w >> 26);
        case (op)
            2:  return "R5";
            3:  return "R6";
            4:  return (s == 0) ? "R2" : "R4";
            5:  return (s != 0) ? "R3" : "R4";
            18: return "R7";
            19: return "R8";
            default: return "R1";
        endcase
    endfunction

    // Drive after a rising edge, compare at the following falling edge.
    task automatic apply(input logic [31:0] p, input logic [31:0] w, input logic [31:0] s, input string tag);
        logic [31:0] e_next, e_lv;
        logic e_tk, e_lw;
        @(posedge clk);
        #2;
        pc = p; instr = w; src_val = s;
        reference(p, w, s, e_next, e_tk, e_lw, e_lv);
        @(negedge clk);
        checks++;
        if (next_pc !== e_next || taken !== e_tk || link_wr !== e_lw || link_val !== e_lv) begin
            errors++;
            $display("FAIL %s: actual next=%08h tk=%0b lw=%0b lv=%08h expected next=%08h tk=%0b lw=%0b lv=%08h",
                     tag, next_pc, taken, link_wr, link_val, e_next, e_tk, e_lw, e_lv);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] rest);
        return {op, rest};
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [5:0]  op_pick [10];
        pc = '0; instr = '0; src_val = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R1: all-zero instruction at address zero, and non-flow opcodes
        apply(32'h0, 32'h0, 32'h0, "R1");
        apply(32'h100, mk(6'h08, 26'h3ff_ffff), 32'h0, "R1");
        apply(32'h200, mk(6'h06, 26'h000_0010), 32'h0, "R1");
        apply(32'h204, mk(6'h11, 26'h000_0010), 32'h5, "R1");
        apply(32'h208, mk(6'h14, 26'h000_0010), 32'h0, "R1");
        apply(32'h20c, mk(6'h3f, 26'h3ff_ffff), 32'h0, "R1");
        // R2: branch if zero, forward and backward
        apply(32'h1000, mk(6'h04, 26'h000_0010), 32'h0, "R2");
        apply(32'h1000, mk(6'h04, 26'h000_fff0), 32'h0, "R2");
        // R3: branch if nonzero, including a top-bit-only source
        apply(32'h2000, mk(6'h05, 26'h000_0040), 32'h5, "R3");
        apply(32'h2000, mk(6'h05, 26'h000_8000), 32'h8000_0000, "R3");
        // R4: branches that fall through
        apply(32'h3000, mk(6'h04, 26'h000_0040), 32'h5, "R4");
        apply(32'h3000, mk(6'h05, 26'h000_0040), 32'h0, "R4");
        // R5: relative jump, forward and to itself via negative offset
        apply(32'h4000, mk(6'h02, 26'h000_1000), 32'h0, "R5");
        apply(32'h4000, mk(6'h02, 26'h3ff_fffc), 32'h0, "R5");
        // R6: relative jump with link
        apply(32'h5000, mk(6'h03, 26'h200_0000), 32'h0, "R6");
        // R7: register jump
        apply(32'h6000, mk(6'h12, 26'h0), 32'hdead_bee0, "R7");
        // R8: register jump with link
        apply(32'h7000, mk(6'h13, 26'h0), 32'h0000_0400, "R8");
        // R9: link stays low for the non-link jump forms
        apply(32'h7100, mk(6'h02, 26'h0), 32'h0, "R9");
        apply(32'h7100, mk(6'h12, 26'h0), 32'h1234, "R9");
        // R10: register jump whose target equals the sequential address
        apply(32'h8000, mk(6'h12, 26'h0), 32'h8004, "R10");
        // R11: wrap at the top of the address space
        apply(32'hffff_fffc, 32'h0, 32'h0, "R11");
        apply(32'hffff_fff8, mk(6'h02, 26'h000_0010), 32'h0, "R11");
        apply(32'h0000_0000, mk(6'h04, 26'h000_fff0), 32'h0, "R11");

        // Pseudo-random mix biased toward flow-changing opcodes.
        op_pick = '{6'h02, 6'h03, 6'h04, 6'h05, 6'h12, 6'h13, 6'h00, 6'h08, 6'h2b, 6'h23};
        lfsr = 32'hace1_2345;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] p, w, s;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            p = {lfsr[29:2], 2'b00} ^ 32'(i << 4);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = {op_pick[lfsr[7:0] % 10], lfsr[31:6]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            s = (lfsr[3:0] < 4) ? 32'h0 : lfsr;
            apply(p, w, s, tag_for(w, s));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule